// File: doc/BRIEF.md
# Interrupt Priority Resolver with Fast Interrupt

This block watches a vector of pending interrupt requests. Each request carries a programmable 4-bit priority level and a routing bit that sends it either to the processor or to a data transfer engine. Every cycle it finds a winner for each of the two destinations.

On the transfer-engine side the programmed levels play no part: the lowest-numbered pending request routed there is reported straight away. On the processor side the ranking works as follows:
- One source can be marked as the fast interrupt, through an 8-bit vector number and an enable bit.
- That source is ranked above everything else and reported at level 15.
- The other sources are ranked by level, with the lower vector number winning a tie.
- The winner is checked against the processor's current mask level and a global enable.

When the processor winner is accepted, the block emits a one-cycle registered strobe carrying the vector number and the level. The processor loads that level as its new mask.

Top module: `ipr_resolver`

## Requirements
- R1: When the fast interrupt is enabled, its vector number (`fast_vec`) names a source below NUM_SRC, and that source is pending and routed to the processor (`req_to_xfer` bit = 0), it wins the processor arbitration over every other source, including other level-15 sources. It is reported at level 15 whatever its priority field holds, even 0.
- R2: Among pending, processor-routed sources other than the fast interrupt, the one with the larger priority field wins.
- R3: When several such sources share the highest level, the source with the smallest vector number (its bit index in `req_pend`) wins.
- R4: A source that is not the fast interrupt and whose priority field is 0 never takes part in processor arbitration.
- R5: A processor winner is accepted only when its effective level is strictly greater than `cpu_mask`. With `cpu_mask` = 15, even the fast interrupt is refused.
- R6: While `glb_ie` is 0, no request is accepted.
- R7: `acc_valid` rises on the clock edge after the cycle in which the acceptance conditions hold, and lasts one cycle. The cycle that follows a strobe never accepts. `acc_vec` and `acc_lvl` carry the vector number and the new mask level, and hold their values between strobes.
- R8: The transfer-engine outputs combinationally report the smallest pending vector number whose `req_to_xfer` bit is 1, whatever the priority fields hold (0 included). Such sources never take part in processor arbitration.
- R9: With `fast_en` at 0, or with `fast_vec` at NUM_SRC or above, no source gets fast treatment.
- R10: After reset, `acc_valid`, `acc_vec` and `acc_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pend | input | NUM_SRC | Pending bit for each source; bit i is vector i |
| req_lvl | input | 4*NUM_SRC | Priority field for each source; bits 4i+3:4i belong to vector i |
| req_to_xfer | input | NUM_SRC | 1 routes the source to the transfer engine, 0 to the processor |
| fast_en | input | 1 | Enables the fast interrupt |
| fast_vec | input | 8 | Vector number of the fast interrupt source |
| cpu_mask | input | 4 | Current processor interrupt mask level |
| glb_ie | input | 1 | Global processor interrupt enable |
| acc_valid | output | 1 | One-cycle accept strobe |
| acc_vec | output | 8 | Vector number of the accepted request |
| acc_lvl | output | 4 | Level of the accepted request (the new mask level) |
| xfer_valid | output | 1 | A transfer-engine request is pending |
| xfer_vec | output | 8 | Vector number of the transfer-engine winner |

## Verification
The processor accept path and the transfer-engine selection both read the same pending vector, so a single cycle can produce a processor strobe and a transfer winner at once. The bench provokes this by scattering random routing bits over dense pending patterns, so most cycles hold requests for both destinations. It also places a zero-level source below the processor winner on the transfer side. A behavioural model ranks the two destinations separately. On every cycle it checks that the transfer result follows vector order alone while the strobe follows level, fast status and mask.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  localparam int LVL_W = 4;
  localparam int VEC_W = 8;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;
  localparam int KEY_W = LVL_W + 1;

  // level used for ranking and masking
  function automatic logic [LVL_W-1:0] eff_level(input logic is_fast, input logic [LVL_W-1:0] lvl);
    return is_fast ? LVL_TOP : lvl;
  endfunction

  // rank key: fast flag above level
  function automatic logic [KEY_W-1:0] rank_key(input logic is_fast, input logic [LVL_W-1:0] lvl);
    return {is_fast, eff_level(is_fast, lvl)};
  endfunction

  function automatic logic may_compete(input logic pend, input logic to_xfer,
                                       input logic is_fast, input logic [LVL_W-1:0] lvl);
    return pend && !to_xfer && (is_fast || lvl != '0);
  endfunction
endpackage

// File: rtl/ipr_cpu_arb.sv
module ipr_cpu_arb
  import ipr_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC*LVL_W-1:0] lvl,
  input  logic [NUM_SRC-1:0]       to_xfer,
  input  logic                     fast_en,
  input  logic [VEC_W-1:0]         fast_vec,
  output logic                     win_valid,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl,
  output logic                     win_fast
);
  logic [NUM_SRC-1:0] is_fast;
  logic [NUM_SRC-1:0] cand;
  logic [KEY_W-1:0]   best_key;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign is_fast[g] = fast_en && (fast_vec == VEC_W'(g));
    assign cand[g]    = may_compete(pend[g], to_xfer[g], is_fast[g], lvl[g*LVL_W +: LVL_W]);
  end

  // ascending scan, replace only on a strictly larger key: ties keep the lower vector
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best_key  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!win_valid || rank_key(is_fast[i], lvl[i*LVL_W +: LVL_W]) > best_key)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best_key  = rank_key(is_fast[i], lvl[i*LVL_W +: LVL_W]);
      end
    end
  end

  assign win_fast = best_key[KEY_W-1];
  assign win_lvl  = best_key[LVL_W-1:0];

  logic fast_live;
  assign fast_live = |(is_fast & cand);

  a_r1_fast_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fast_live |-> (win_fast && is_fast[win_idx] && win_lvl == LVL_TOP));
  a_r4_no_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_lvl != '0 && pend[win_idx] && !to_xfer[win_idx]));
  a_r8_xfer_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == to_xfer) |-> !win_valid);
endmodule

// File: rtl/ipr_xfer_arb.sv
module ipr_xfer_arb
  import ipr_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] to_xfer,
  output logic               xfer_valid,
  output logic [VEC_W-1:0]   xfer_vec
);
  logic [NUM_SRC-1:0] live;
  assign live = pend & to_xfer;

  // descending scan so the lowest vector is written last
  always_comb begin
    xfer_vec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) xfer_vec = VEC_W'(i);
    end
  end
  assign xfer_valid = |live;

  a_r8_xfer_pick: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (pend[xfer_vec] && to_xfer[xfer_vec]));
endmodule

// File: rtl/ipr_accept.sv
module ipr_accept
  import ipr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic [LVL_W-1:0] cpu_mask,
  input  logic             glb_ie,
  output logic             acc_valid,
  output logic [VEC_W-1:0] acc_vec,
  output logic [LVL_W-1:0] acc_lvl
);
  logic take;
  assign take = glb_ie && win_valid && (win_lvl > cpu_mask) && !acc_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_vec   <= '0;
      acc_lvl   <= '0;
    end else begin
      acc_valid <= take;
      if (take) begin
        acc_vec <= VEC_W'(win_idx);
        acc_lvl <= win_lvl;
      end
    end
  end

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> !acc_valid);
  a_r5_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid) |-> (acc_lvl > $past(cpu_mask)));
  a_r6_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid) |-> $past(glb_ie));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (acc_valid || ($stable(acc_vec) && $stable(acc_lvl))));
endmodule

// File: rtl/ipr_resolver.sv
module ipr_resolver
  import ipr_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req_pend,
  input  logic [NUM_SRC*LVL_W-1:0] req_lvl,
  input  logic [NUM_SRC-1:0]       req_to_xfer,
  input  logic                     fast_en,
  input  logic [VEC_W-1:0]         fast_vec,
  input  logic [LVL_W-1:0]         cpu_mask,
  input  logic                     glb_ie,
  output logic                     acc_valid,
  output logic [VEC_W-1:0]         acc_vec,
  output logic [LVL_W-1:0]         acc_lvl,
  output logic                     xfer_valid,
  output logic [VEC_W-1:0]         xfer_vec
);
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic             win_fast;

  ipr_cpu_arb #(.NUM_SRC(NUM_SRC)) u_cpu (
    .clk(clk), .rst_n(rst_n), .pend(req_pend), .lvl(req_lvl), .to_xfer(req_to_xfer),
    .fast_en(fast_en), .fast_vec(fast_vec),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl), .win_fast(win_fast));

  ipr_xfer_arb #(.NUM_SRC(NUM_SRC)) u_xfer (
    .clk(clk), .rst_n(rst_n), .pend(req_pend), .to_xfer(req_to_xfer),
    .xfer_valid(xfer_valid), .xfer_vec(xfer_vec));

  ipr_accept #(.IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl),
    .cpu_mask(cpu_mask), .glb_ie(glb_ie),
    .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_lvl(acc_lvl));

  a_r5_fast_refused_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (win_fast && cpu_mask == LVL_TOP) |=> !acc_valid);
endmodule

// File: tb/ipr_resolver_test.sv
`timescale 1ns/1ps
module ipr_resolver_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   req_pend = '0;
  logic [N*4-1:0] req_lvl = '0;
  logic [N-1:0]   req_to_xfer = '0;
  logic           fast_en = 1'b0;
  logic [7:0]     fast_vec = '0;
  logic [3:0]     cpu_mask = '0;
  logic           glb_ie = 1'b0;
  logic           acc_valid;
  logic [7:0]     acc_vec;
  logic [3:0]     acc_lvl;
  logic           xfer_valid;
  logic [7:0]     xfer_vec;

  ipr_resolver #(.NUM_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_lvl(req_lvl), .req_to_xfer(req_to_xfer),
    .fast_en(fast_en), .fast_vec(fast_vec), .cpu_mask(cpu_mask), .glb_ie(glb_ie),
    .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_lvl(acc_lvl),
    .xfer_valid(xfer_valid), .xfer_vec(xfer_vec));

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // stimulus for the next cycle
  logic [N-1:0]   s_pend = '0;
  int             s_lvl [N];
  logic [N-1:0]   s_xfer = '0;
  bit             s_fen = 0;
  int             s_fvec = 0;
  int             s_mask = 0;
  bit             s_ie = 0;

  // model state: expected registered outputs
  bit e_valid = 0;
  int e_vec = 0;
  int e_lvl = 0;

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    int xv, best, bi, bl, r;
    bit xok, tk;
    @(negedge clk);
    check(tag, int'(acc_valid), int'(e_valid), "acc_valid");
    check(tag, int'(acc_vec), e_vec, "acc_vec");
    check(tag, int'(acc_lvl), e_lvl, "acc_lvl");
    req_pend = s_pend; req_to_xfer = s_xfer; fast_en = s_fen; fast_vec = 8'(s_fvec);
    cpu_mask = 4'(s_mask); glb_ie = s_ie;
    for (int i = 0; i < N; i++) req_lvl[i*4 +: 4] = 4'(s_lvl[i]);
    #1;
    xok = 0; xv = 0;
    for (int i = 0; i < N; i++) if (!xok && s_pend[i] && s_xfer[i]) begin xok = 1; xv = i; end
    check(tag, int'(xfer_valid), int'(xok), "xfer_valid");
    if (xok) check(tag, int'(xfer_vec), xv, "xfer_vec");
    best = -1; bi = 0; bl = 0;
    for (int i = N - 1; i >= 0; i--) begin
      bit f;
      f = s_fen && (s_fvec == i);
      if (s_pend[i] && !s_xfer[i] && (f || s_lvl[i] != 0)) begin
        r = f ? 16 : s_lvl[i];
        if (r >= best) begin best = r; bi = i; bl = f ? 15 : s_lvl[i]; end
      end
    end
    tk = s_ie && best >= 0 && bl > s_mask && !e_valid;
    e_valid = tk;
    if (tk) begin e_vec = bi; e_lvl = bl; end
  endtask

  task automatic clear();
    s_pend = '0; s_xfer = '0; s_fen = 0; s_fvec = 0; s_mask = 0; s_ie = 1;
    for (int i = 0; i < N; i++) s_lvl[i] = 0;
  endtask

  task automatic settle(string tag);
    cyc(tag); cyc(tag); cyc(tag);
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    @(negedge clk);
    check("R10", int'(acc_valid), 0, "acc_valid");
    check("R10", int'(acc_vec), 0, "acc_vec");
    check("R10", int'(acc_lvl), 0, "acc_lvl");

    // R2 larger level wins
    clear(); s_pend[3] = 1; s_lvl[3] = 4; s_pend[9] = 1; s_lvl[9] = 11; settle("R2");
    // R3 tie goes to the lower vector
    clear(); s_pend[5] = 1; s_lvl[5] = 7; s_pend[12] = 1; s_lvl[12] = 7; s_pend[2] = 1; s_lvl[2] = 3; settle("R3");
    // R1 fast with field 0 beats a level-15 source
    clear(); s_pend[1] = 1; s_lvl[1] = 15; s_pend[10] = 1; s_lvl[10] = 0; s_fen = 1; s_fvec = 10; settle("R1");
    // R9 fast disabled: level 15 source wins, field-0 source ignored
    clear(); s_pend[1] = 1; s_lvl[1] = 15; s_pend[10] = 1; s_fen = 0; s_fvec = 10; settle("R9");
    // R9 fast vector out of range
    clear(); s_pend[4] = 1; s_lvl[4] = 2; s_fen = 1; s_fvec = 200; settle("R9");
    // R4 zero level never accepted
    clear(); s_pend[0] = 1; s_lvl[0] = 0; s_pend[7] = 1; s_lvl[7] = 0; settle("R4");
    // R5 equal to mask refused, above mask accepted, mask 15 refuses fast
    clear(); s_pend[6] = 1; s_lvl[6] = 9; s_mask = 9; settle("R5");
    s_mask = 8; settle("R5");
    clear(); s_pend[6] = 1; s_fen = 1; s_fvec = 6; s_mask = 15; settle("R5");
    // R6 global enable low
    clear(); s_pend[8] = 1; s_lvl[8] = 12; s_ie = 0; settle("R6");
    // R7 held request pulses with a gap
    clear(); s_pend[13] = 1; s_lvl[13] = 5; cyc("R7"); cyc("R7"); cyc("R7"); cyc("R7"); cyc("R7");
    // R8 transfer side ignores levels; routed source not a processor candidate
    clear(); s_pend[2] = 1; s_xfer[2] = 1; s_lvl[2] = 0; s_pend[9] = 1; s_xfer[9] = 1; s_lvl[9] = 15;
    s_pend[11] = 1; s_lvl[11] = 3; settle("R8");
    clear(); s_pend[3] = 1; s_xfer[3] = 1; s_fen = 1; s_fvec = 3; settle("R8");

    // random: both destinations busy together
    for (int k = 0; k < 3000; k++) begin
      s_pend = N'($urandom); s_xfer = N'($urandom) & N'($urandom);
      for (int i = 0; i < N; i++) s_lvl[i] = $urandom_range(0, 15);
      s_fen = $urandom_range(0, 1); s_fvec = $urandom_range(0, 19);
      s_mask = $urandom_range(0, 15); s_ie = ($urandom_range(0, 7) != 0);
      cyc((k % 2 == 0) ? "R2" : "R8");
    end
    clear(); settle("R7");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule